// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block walks a linked list of 32-bit capability headers kept in a 4 KB configuration memory. The memory sits outside the block and is reached through one synchronous read port and one write port. Each read returns data on the cycle after it is issued. The chain always begins at byte offset 256.

A lookup takes a capability identifier and returns two offsets: the byte offset of the first matching header (or 0), and the offset of the header visited just before it. The identifier input is one bit wider than the 16-bit field it is compared against. A value with that extra bit set can never match, so the walk runs to the end of the list and returns the tail offset.

An append adds a new header at a given offset. When that offset is 256, the block writes the header directly. Otherwise the block walks to the tail, rewrites only the tail's next-pointer field, and then writes the new header with an empty next pointer. Pointers that are misaligned, that fall outside the legal window, or that form a cycle stop the walk and raise an error code.

Top module: `ecap_walker`

## Requirements
- R1: A lookup with `find_id[16]`=0 returns in `found_off` the byte offset of the first header on the chain whose bits 15:0 equal `find_id[15:0]`, and in `prev_off` the offset of the header visited before it (0 when the match is the header at 256), with `err_code`=0.
- R2: When the 32-bit word at byte offset 256 is zero, a lookup reports `found_off`=0, `prev_off`=0 and `err_code`=0 after exactly one memory read.
- R3: When a lookup reaches a header whose next field is 0 without a match, it reports `found_off`=0 and `prev_off` equal to that last header's offset. A `find_id` with bit 16 set never matches, so it always yields the tail offset.
- R4: Header layout: identifier in bits 15:0, version in bits 19:16, next byte offset in bits 31:20. Only bits 15:0 take part in matching.
- R5: A nonzero next field whose two low bits are not both zero stops the walk with `err_code`=2, `found_off`=0 and `prev_off` equal to the header holding that pointer. The bad offset is never read.
- R6: A nonzero, aligned next field below 256 or above 4088 stops the walk with `err_code`=1, `found_off`=0 and `prev_off` equal to the header holding that pointer. The memory is never read outside 256..4088.
- R7: A walk that visits 1024 headers without reaching an end stops with `err_code`=3 and no further reads.
- R8: An append with `new_off`=256 issues no read and writes the word `{12'd0, new_ver, new_id}` to byte offset 256. It then reports `found_off`=256 and `prev_off`=0.
- R9: An append at any other legal offset walks to the tail. It keeps bits 19:0 of the tail header and writes `new_off` into its bits 31:20, then writes `{12'd0, new_ver, new_id}` at `new_off`. It reports `found_off`=`new_off` and `prev_off`=tail, using exactly two writes.
- R10: An append whose `new_off` is misaligned (`err_code`=2) or outside 256..4088 (`err_code`=1) touches no memory. An append to a non-256 offset on an empty chain reports `err_code`=1 and writes nothing. Any walk error suppresses all writes.
- R11: `start` is taken only while idle and is ignored while `busy`. `busy` stays high until the cycle in which `done` pulses high for exactly one cycle. Each visited header costs exactly one read. The results stay stable until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (idle only) |
| op_append | input | 1 | 0 = lookup, 1 = append |
| find_id | input | 17 | Identifier to look up; bit 16 set never matches |
| new_id | input | 16 | Identifier for an appended header |
| new_ver | input | 4 | Version for an appended header |
| new_off | input | 12 | Byte offset of an appended header |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| found_off | output | 12 | Matching or appended offset, 0 if none |
| prev_off | output | 12 | Offset of previously visited header / tail |
| err_code | output | 2 | 0 none, 1 window, 2 alignment, 3 cycle |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 10 | Memory word address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 10 | Memory write word address |
| mem_wr_data | output | 32 | Memory write data |

## Verification
On every cycle, the assertions confirm four things. Reads never leave the 256..4088 window. Writes happen only during an append. `done` is a single-cycle pulse that always closes a busy period. The hop counter never steps past its limit.

Some behaviour only the bench's scenarios can show, because each case needs a prepared chain. These are:
- the actual offsets returned for hits, misses and tail searches
- the exact read and write counts per operation
- the in-place rewrite of only the tail's next field
- the error codes for misaligned, out-of-window and cyclic chains

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_EVAL,
    S_WTAIL,
    S_WNEW,
    S_FIN
  } walk_st_t;

  typedef enum logic [1:0] {
    E_NONE  = 2'd0,
    E_RANGE = 2'd1,
    E_ALIGN = 2'd2,
    E_LOOP  = 2'd3
  } walk_err_t;
endpackage

// File: rtl/ecap_off_chk.sv
module ecap_off_chk #(
  parameter int ADDR_W = 12,
  parameter int BASE   = 256
) (
  input  logic [ADDR_W-1:0] off,
  output logic              misaligned,
  output logic              out_of_win
);
  localparam int LAST = (1 << ADDR_W) - 8;
  localparam logic [ADDR_W-1:0] BASE_OFF = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] LAST_OFF = ADDR_W'(LAST);

  always_comb begin
    misaligned = |off[1:0];
    out_of_win = (off < BASE_OFF) || (off > LAST_OFF);
  end
endmodule

// File: rtl/ecap_hop_ctr.sv
module ecap_hop_ctr #(
  parameter int MAX_HOPS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = (MAX_HOPS > 1) ? $clog2(MAX_HOPS) : 1;
  localparam logic [CW-1:0] LIM = CW'(MAX_HOPS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || inc) cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == LIM);

  // R7
  hop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !at_limit);
endmodule

// File: rtl/ecap_walker.sv
module ecap_walker
  import ecap_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int ID_W     = 16,
  parameter int VER_W    = 4,
  parameter int BASE     = 256,
  parameter int MAX_HOPS = 1024
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          op_append,
  input  logic [ID_W:0]                 find_id,
  input  logic [ID_W-1:0]               new_id,
  input  logic [VER_W-1:0]              new_ver,
  input  logic [ADDR_W-1:0]             new_off,
  output logic                          busy,
  output logic                          done,
  output logic [ADDR_W-1:0]             found_off,
  output logic [ADDR_W-1:0]             prev_off,
  output logic [1:0]                    err_code,
  output logic                          mem_rd_en,
  output logic [ADDR_W-3:0]             mem_rd_addr,
  input  logic [ID_W+VER_W+ADDR_W-1:0]  mem_rd_data,
  output logic                          mem_wr_en,
  output logic [ADDR_W-3:0]             mem_wr_addr,
  output logic [ID_W+VER_W+ADDR_W-1:0]  mem_wr_data
);
  localparam int DW      = ID_W + VER_W + ADDR_W;
  localparam int NXT_LSB = ID_W + VER_W;
  localparam int LAST    = (1 << ADDR_W) - 8;
  localparam logic [ADDR_W-1:0] BASE_OFF = ADDR_W'(BASE);

  walk_st_t               st_q, st_d;
  logic                   op_q, op_d;
  logic [ID_W:0]          id_q, id_d;
  logic [ID_W-1:0]        nid_q, nid_d;
  logic [VER_W-1:0]       nver_q, nver_d;
  logic [ADDR_W-1:0]      noff_q, noff_d;
  logic [ADDR_W-1:0]      cur_q, cur_d;
  logic [ADDR_W-1:0]      prev_q, prev_d;
  logic [ADDR_W-1:0]      found_q, found_d;
  logic [DW-1:0]          hdr_q, hdr_d;
  walk_err_t              err_q, err_d;

  logic                   hop_clr, hop_inc, hop_lim;
  logic                   nx_mis, nx_oow, nw_mis, nw_oow;
  logic [ADDR_W-1:0]      nxt;
  logic                   id_hit, first_visit;

  assign nxt         = mem_rd_data[DW-1:NXT_LSB];
  assign id_hit      = !id_q[ID_W] && (mem_rd_data[ID_W-1:0] == id_q[ID_W-1:0]);
  assign first_visit = (prev_q == '0);

  ecap_off_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_nxt_chk (
    .off(nxt), .misaligned(nx_mis), .out_of_win(nx_oow));

  ecap_off_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_new_chk (
    .off(new_off), .misaligned(nw_mis), .out_of_win(nw_oow));

  ecap_hop_ctr #(.MAX_HOPS(MAX_HOPS)) u_hops (
    .clk(clk), .rst_n(rst_n), .clr(hop_clr), .inc(hop_inc), .at_limit(hop_lim));

  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    id_d    = id_q;
    nid_d   = nid_q;
    nver_d  = nver_q;
    noff_d  = noff_q;
    cur_d   = cur_q;
    prev_d  = prev_q;
    found_d = found_q;
    hdr_d   = hdr_q;
    err_d   = err_q;
    hop_clr = 1'b0;
    hop_inc = 1'b0;
    mem_rd_en   = 1'b0;
    mem_wr_en   = 1'b0;
    mem_wr_addr = '0;
    mem_wr_data = '0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          op_d    = op_append;
          id_d    = op_append ? {1'b1, {ID_W{1'b0}}} : find_id;
          nid_d   = new_id;
          nver_d  = new_ver;
          noff_d  = new_off;
          cur_d   = BASE_OFF;
          prev_d  = '0;
          found_d = '0;
          err_d   = E_NONE;
          hop_clr = 1'b1;
          if (!op_append)                 st_d = S_RD;
          else if (nw_mis)                begin err_d = E_ALIGN; st_d = S_FIN; end
          else if (nw_oow)                begin err_d = E_RANGE; st_d = S_FIN; end
          else if (new_off == BASE_OFF)   st_d = S_WNEW;
          else                            st_d = S_RD;
        end
      end
      S_RD: begin
        mem_rd_en = 1'b1;
        st_d      = S_EVAL;
      end
      S_EVAL: begin
        hdr_d = mem_rd_data;
        if (first_visit && (mem_rd_data == '0)) begin
          if (op_q) err_d = E_RANGE;
          st_d = S_FIN;
        end else if (id_hit) begin
          found_d = cur_q;
          st_d    = S_FIN;
        end else begin
          prev_d = cur_q;
          if (nxt == '0)   st_d = op_q ? S_WTAIL : S_FIN;
          else if (nx_mis) begin err_d = E_ALIGN; st_d = S_FIN; end
          else if (nx_oow) begin err_d = E_RANGE; st_d = S_FIN; end
          else if (hop_lim) begin err_d = E_LOOP; st_d = S_FIN; end
          else begin
            cur_d   = nxt;
            hop_inc = 1'b1;
            st_d    = S_RD;
          end
        end
      end
      S_WTAIL: begin
        mem_wr_en   = 1'b1;
        mem_wr_addr = prev_q[ADDR_W-1:2];
        mem_wr_data = {noff_q, hdr_q[NXT_LSB-1:0]};
        st_d        = S_WNEW;
      end
      S_WNEW: begin
        mem_wr_en   = 1'b1;
        mem_wr_addr = noff_q[ADDR_W-1:2];
        mem_wr_data = {{ADDR_W{1'b0}}, nver_q, nid_q};
        found_d     = noff_q;
        st_d        = S_FIN;
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      op_q    <= 1'b0;
      id_q    <= '0;
      nid_q   <= '0;
      nver_q  <= '0;
      noff_q  <= '0;
      cur_q   <= '0;
      prev_q  <= '0;
      found_q <= '0;
      hdr_q   <= '0;
      err_q   <= E_NONE;
    end else begin
      st_q    <= st_d;
      op_q    <= op_d;
      id_q    <= id_d;
      nid_q   <= nid_d;
      nver_q  <= nver_d;
      noff_q  <= noff_d;
      cur_q   <= cur_d;
      prev_q  <= prev_d;
      found_q <= found_d;
      hdr_q   <= hdr_d;
      err_q   <= err_d;
    end
  end

  assign busy        = (st_q != S_IDLE) && (st_q != S_FIN);
  assign done        = (st_q == S_FIN);
  assign found_off   = found_q;
  assign prev_off    = prev_q;
  assign err_code    = err_q;
  assign mem_rd_addr = cur_q[ADDR_W-1:2];

  // R6
  rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> ({mem_rd_addr, 2'b00} >= BASE && {mem_rd_addr, 2'b00} <= LAST));

  // R10
  wr_only_append_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (op_q && err_q == E_NONE));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R5
  err_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code != 2'd0) |-> (found_off == '0));
endmodule

// File: tb/sim_ecap_walker.sv
module sim_ecap_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_append = 1'b0;
  logic [16:0] find_id = '0;
  logic [15:0] new_id = '0;
  logic [3:0]  new_ver = '0;
  logic [11:0] new_off = '0;
  logic        busy, done, mem_rd_en, mem_wr_en;
  logic [11:0] found_off, prev_off;
  logic [1:0]  err_code;
  logic [9:0]  mem_rd_addr, mem_wr_addr;
  logic [31:0] mem_rd_data, mem_wr_data;

  logic [31:0] mem [0:1023];
  int nrd = 0, nwr = 0, ntot = 0, nbad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecap_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_append(op_append),
    .find_id(find_id), .new_id(new_id), .new_ver(new_ver), .new_off(new_off),
    .busy(busy), .done(done), .found_off(found_off), .prev_off(prev_off),
    .err_code(err_code), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data));

  always @(posedge clk) begin
    if (mem_rd_en) begin mem_rd_data <= mem[mem_rd_addr]; nrd = nrd + 1; end
    if (mem_wr_en) begin mem[mem_wr_addr] <= mem_wr_data; nwr = nwr + 1; end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      nbad = nbad + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic void ref_find(input logic [16:0] id, output logic [11:0] f,
                                   output logic [11:0] p, output logic [1:0] e, output int v);
    logic [11:0] cur, n;
    logic [31:0] h;
    f = 0; p = 0; e = 0; v = 0; cur = 12'd256;
    if (mem[64] == 32'd0) begin v = 1; return; end
    for (int k = 0; k < 2000; k++) begin
      h = mem[cur[11:2]]; v++;
      if (!id[16] && h[15:0] == id[15:0]) begin f = cur; return; end
      p = cur; n = h[31:20];
      if (n == 0) return;
      if (n[1:0] != 0) begin e = 2; return; end
      if (n < 12'd256 || n > 12'd4088) begin e = 1; return; end
      if (v == 1024) begin e = 3; return; end
      cur = n;
    end
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
  endtask

  task automatic run(input logic ap, input logic [16:0] id, input logic [15:0] nid,
                     input logic [3:0] nv, input logic [11:0] no);
    int t;
    @(negedge clk);
    nrd = 0; nwr = 0;
    op_append = ap; find_id = id; new_id = nid; new_ver = nv; new_off = no;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic check_find(input string req, input logic [16:0] id);
    logic [11:0] f, p; logic [1:0] e; int v;
    ref_find(id, f, p, e, v);
    run(1'b0, id, 16'd0, 4'd0, 12'd0);
    chk({req, " found_off"}, 32'(found_off), 32'(f));
    chk({req, " prev_off"},  32'(prev_off),  32'(p));
    chk({req, " err_code"},  32'(err_code),  32'(e));
    chk("R11 reads per header", nrd, v);
    @(negedge clk);
    chk("R11 done single pulse", 32'(done), 32'd0);
  endtask

  logic [11:0] offs [0:8];
  logic [15:0] ids  [0:8];

  task automatic build(input int n, input int r);
    clear_mem();
    for (int k = 0; k <= n; k++) begin
      offs[k] = (k == 0) ? 12'd256 : 12'(256 + 16 * (((k * 37 + r) % 239) + 1));
      ids[k]  = 16'($urandom);
    end
    if (offs[1] == 12'd256) offs[1] = 12'd4080;
    for (int k = 0; k < n; k++)
      mem[offs[k][11:2]] = {(k == n - 1) ? 12'd0 : offs[k+1], 4'($urandom), ids[k]};
  endtask

  initial begin
    logic [11:0] f, p; logic [1:0] e; int v;
    logic [31:0] old;
    void'($urandom(32'd4242));
    clear_mem();
    repeat (3) @(negedge clk);
    chk("R11 reset busy", 32'(busy), 0);
    chk("R11 reset done", 32'(done), 0);
    chk("R11 reset rd_en", 32'(mem_rd_en), 0);
    chk("R11 reset err", 32'(err_code), 0);
    rst_n = 1'b1;

    // R2 empty chain
    check_find("R2 empty", 17'h00000);
    // R10 append off-base onto empty chain
    run(1'b1, 17'd0, 16'h1234, 4'h2, 12'h200);
    chk("R10 empty append err", 32'(err_code), 1);
    chk("R10 empty append writes", nwr, 0);
    // R8 / R4 append at base
    run(1'b1, 17'd0, 16'hBEEF, 4'h5, 12'd256);
    chk("R8 base found", 32'(found_off), 256);
    chk("R8 base prev", 32'(prev_off), 0);
    chk("R8 base reads", nrd, 0);
    chk("R8 R4 header word", mem[64], 32'h0005_BEEF);

    // R10 bad new offsets
    run(1'b1, 17'd0, 16'h1, 4'h1, 12'h203);
    chk("R10 misaligned err", 32'(err_code), 2);
    chk("R10 misaligned touches", nrd + nwr, 0);
    run(1'b1, 17'd0, 16'h1, 4'h1, 12'h080);
    chk("R10 low window err", 32'(err_code), 1);
    run(1'b1, 17'd0, 16'h1, 4'h1, 12'hFFC);
    chk("R10 high window err", 32'(err_code), 1);
    chk("R10 window touches", nrd + nwr, 0);

    // random chains: R1, R3, R9, R4
    for (int it = 0; it < 30; it++) begin
      int n, k;
      n = 1 + int'($urandom % 7);
      build(n, int'($urandom % 239));
      k = int'($urandom % n);
      check_find("R1 hit", {1'b0, ids[k]});
      check_find("R3 miss", {1'b0, 16'($urandom)});
      check_find("R3 tail search", {1'b1, 16'($urandom)});
      ref_find(17'h10000, f, p, e, v);
      old = mem[p[11:2]];
      ids[8] = 16'($urandom);
      run(1'b1, 17'd0, ids[8], 4'h9, offs[n]);
      chk("R9 found", 32'(found_off), 32'(offs[n]));
      chk("R9 prev tail", 32'(prev_off), 32'(p));
      chk("R9 writes", nwr, 2);
      chk("R9 tail rewrite", mem[p[11:2]], {offs[n], old[19:0]});
      chk("R9 R4 new header", mem[offs[n][11:2]], {12'd0, 4'h9, ids[8]});
      check_find("R1 after append", {1'b0, ids[8]});
    end

    // R5 misaligned next
    clear_mem(); mem[64] = {12'h102, 4'h1, 16'h0001};
    check_find("R5 align", 17'h00077);
    // R6 window errors
    mem[64] = {12'h080, 4'h1, 16'h0001};
    check_find("R6 low", 17'h00077);
    mem[64] = {12'h200, 4'h1, 16'h0001}; mem[128] = {12'hFFC, 4'h3, 16'h0002};
    check_find("R6 high", 17'h00077);
    // R9 append blocked by walk error
    run(1'b1, 17'd0, 16'h5, 4'h1, 12'h300);
    chk("R10 walk err no write", nwr, 0);
    // R7 cyclic chain
    mem[64] = {12'd256, 4'h1, 16'hAAAA};
    check_find("R7 loop", 17'h00001);
    chk("R7 loop code", 32'(err_code), 3);
    // R4 version/next ignored in matching
    mem[64] = {12'd0, 4'hF, 16'h1357};
    check_find("R4 id only", 17'h01357);

    // R11 start ignored while busy
    build(6, 11);
    ref_find({1'b0, ids[5]}, f, p, e, v);
    @(negedge clk);
    op_append = 1'b0; find_id = {1'b0, ids[5]}; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    find_id = {1'b0, ids[0]}; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    chk("R11 start ignored found", 32'(found_off), 32'(f));
    chk("R11 start ignored prev", 32'(prev_off), 32'(p));
    repeat (2) @(negedge clk);
    chk("R11 results held", 32'(found_off), 32'(f));

    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule